// File: doc/BRIEF.md
# PHY Configuration Test-Port Writer

This block writes one register of a PHY configuration port that works by slow, hand-driven signalling. The port has three lines: a clock line, an enable line and an 8-bit data bus. The PHY reads the bus as a register address when the clock line falls while enable is high. It reads the bus as the register value when the clock line rises while enable is low. The port has no separate strobe or valid line. An address phase and a data phase differ only in which clock edge occurs and at what enable level.

A client puts an address byte and a value byte on its inputs and pulses `start` for one cycle. The block copies both bytes into internal registers. It then steps the port lines through seven ordered states and holds each state for `HOLD_CYCLES` system clocks, which meets the port's setup and hold times. When the final rising edge has been held, the block raises `done` for one cycle. The writer drops `start` requests that arrive while a write is in progress.

Top module: `phy_cfg_writer`

## Requirements
- R1: Out of reset, and whenever `busy` is low, the port lines rest at `port_clk`=1, `port_en`=0 and `port_din`=0.
- R2: An accepted write drives seven steps in this order. Each entry gives `port_clk`, `port_en`, `port_din`: (1,0,0), (1,0,addr), (1,1,addr), (0,1,addr), (0,0,addr), (0,0,value), (1,0,value).
- R3: Every fall of `port_clk` happens while `port_en` is 1 and `port_din` carries the address byte.
- R4: Every rise of `port_clk` during a write happens while `port_en` is 0 and `port_din` carries the value byte.
- R5: Each step lasts exactly `HOLD_CYCLES` system clocks, so a write takes 7×`HOLD_CYCLES` cycles from the edge that accepts `start`.
- R6: `busy` goes high in the cycle after the edge that accepts `start` and stays high until the write ends.
- R7: `done` is high for exactly one cycle, the cycle right after the final step, and `busy` is low in that cycle.
- R8: The block ignores `start` while `busy` is high. It accepts `start` in any cycle where `busy` is low, including the cycle in which `done` is high.
- R9: The address and value bytes are taken from `addr_in` and `value_in` at the accepting edge. Later changes on those inputs do not affect the write.
- R10: At most one of `port_clk`, `port_en` and `port_din` changes in any one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a write |
| addr_in | input | BYTE_W | Register address byte |
| value_in | input | BYTE_W | Register value byte |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse when the write has finished |
| port_clk | output | 1 | Configuration port clock line |
| port_en | output | 1 | Configuration port enable line |
| port_din | output | BYTE_W | Configuration port data bus |

## Verification
The hardest case to reach from the ports is a `start` pulse that lands on the exact cycle where `done` is high. At that point `busy` has just dropped and the next write must begin with no idle gap. The stimulus reaches this case by timing a second request against the known 7×`HOLD_CYCLES` length of the first write, so that the two writes run back to back.

Other stimulus checks that a write ignores its inputs while it runs. It injects `start` pulses in the middle of a write and randomises `addr_in` and `value_in` every cycle. Every cycle of every write is then compared against the step table.

// File: rtl/phy_cfg_writer.sv
module phy_cfg_writer #(
  parameter int BYTE_W      = 8,
  parameter int HOLD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] addr_in,
  input  logic [BYTE_W-1:0] value_in,
  output logic              busy,
  output logic              done,
  output logic              port_clk,
  output logic              port_en,
  output logic [BYTE_W-1:0] port_din
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PARK, ST_ADDR, ST_ARM, ST_LATCH, ST_DISARM, ST_DATA, ST_COMMIT
  } step_t;

  step_t             st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] addr_q, value_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      addr_q  <= '0;
      value_q <= '0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          st      <= ST_PARK;
          cnt     <= '0;
          addr_q  <= addr_in;
          value_q <= value_in;
        end
      end else if (cnt == LAST) begin
        cnt <= '0;
        if (st == ST_COMMIT) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end else begin
          st <= step_t'(st + 3'd1);
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy     = (st != ST_IDLE);
  assign port_clk = !(st inside {ST_LATCH, ST_DISARM, ST_DATA});
  assign port_en  = (st inside {ST_ARM, ST_LATCH});

  always_comb begin
    case (st)
      ST_ADDR, ST_ARM, ST_LATCH, ST_DISARM: port_din = addr_q;
      ST_DATA, ST_COMMIT:                   port_din = value_q;
      default:                              port_din = '0;
    endcase
  end
endmodule

module phy_cfg_writer_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              port_clk,
  input logic              port_en,
  input logic [BYTE_W-1:0] port_din
);
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (port_clk && !port_en && port_din == '0));

  a_r3_fall_with_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_clk) |-> port_en);

  a_r4_rise_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_clk) |-> !port_en);

  a_r6_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  a_r10_one_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!$stable(port_clk), !$stable(port_en), !$stable(port_din)}) <= 1);
endmodule

bind phy_cfg_writer phy_cfg_writer_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/phy_cfg_writer_test.sv
`timescale 1ns/1ps
module phy_cfg_writer_test;
  localparam int BW = 8;
  localparam int H  = 4;
  localparam int WR = 7 * H;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [BW-1:0] addr_in = '0, value_in = '0;
  logic          busy, done, port_clk, port_en;
  logic [BW-1:0] port_din;

  int n_chk = 0;
  int n_fail = 0;

  phy_cfg_writer #(.BYTE_W(BW), .HOLD_CYCLES(H)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
    .value_in(value_in), .busy(busy), .done(done), .port_clk(port_clk),
    .port_en(port_en), .port_din(port_din));

  always #2.5 clk = ~clk;

  // {busy, done, port_clk, port_en, port_din} expected j cycles after acceptance
  function automatic logic [BW+3:0] expect_at(int j, logic [BW-1:0] a, logic [BW-1:0] v);
    if (j >= WR) return {1'b0, (j == WR), 1'b1, 1'b0, {BW{1'b0}}};
    case (j / H)
      0: return {2'b10, 1'b1, 1'b0, {BW{1'b0}}};
      1: return {2'b10, 1'b1, 1'b0, a};
      2: return {2'b10, 1'b1, 1'b1, a};
      3: return {2'b10, 1'b0, 1'b1, a};
      4: return {2'b10, 1'b0, 1'b0, a};
      5: return {2'b10, 1'b0, 1'b0, v};
      default: return {2'b10, 1'b1, 1'b0, v};
    endcase
  endfunction

  function automatic string tag_at(int j);
    if (j == WR) return "R7";
    if (j > WR)  return "R1";
    case (j / H)
      3: return "R3";
      6: return "R4";
      default: return "R2/R5";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic launch(logic [BW-1:0] a, logic [BW-1:0] v);
    start = 1'b1; addr_in = a; value_in = v;
    @(negedge clk);
  endtask

  // poke: inject ignored start mid-write (R8); chain: start again in the done cycle
  task automatic follow(logic [BW-1:0] a, logic [BW-1:0] v, bit poke, bit chain,
                        logic [BW-1:0] na, logic [BW-1:0] nv);
    for (int k = 1; k <= WR + 2; k++) begin
      logic [BW+3:0] e, got;
      e   = expect_at(k - 1, a, v);
      got = {busy, done, port_clk, port_en, port_din};
      check(got == e, tag_at(k - 1), 32'(got), 32'(e));
      addr_in  = BW'($urandom);   // R9: inputs wander during the write
      value_in = BW'($urandom);
      start    = poke && (k == 2 * H || k == WR - 1);
      if (chain && k == WR + 1) begin
        start = 1'b1; addr_in = na; value_in = nv;   // R8: accepted while done is high
        @(negedge clk);
        return;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check({busy, done, port_clk, port_en, port_din} == {4'b0010, 8'h00}, "R1",
          32'({busy, done, port_clk, port_en, port_din}), 32'h200);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, port_clk, port_en, port_din} == {4'b0010, 8'h00}, "R1",
          32'({busy, done, port_clk, port_en, port_din}), 32'h200);

    launch(8'h00, 8'hFF); follow(8'h00, 8'hFF, 1'b0, 1'b0, '0, '0);
    launch(8'hFF, 8'h00); follow(8'hFF, 8'h00, 1'b0, 1'b0, '0, '0);
    launch(8'h5A, 8'hA5); follow(8'h5A, 8'hA5, 1'b1, 1'b0, '0, '0);
    // back-to-back write started in the done cycle (R6, R8)
    launch(8'h3C, 8'hC3); follow(8'h3C, 8'hC3, 1'b0, 1'b1, 8'h81, 8'h7E);
    follow(8'h81, 8'h7E, 1'b0, 1'b0, '0, '0);

    for (int i = 0; i < 30; i++) begin
      logic [BW-1:0] a, v;
      a = BW'($urandom); v = BW'($urandom);
      launch(a, v);
      follow(a, v, 1'($urandom), 1'b0, '0, '0);
      repeat ($urandom_range(0, 3)) begin
        check({busy, done, port_clk, port_en, port_din} == {4'b0010, 8'h00}, "R1",
              32'({busy, done, port_clk, port_en, port_din}), 32'h200);
        @(negedge clk);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule